// File: doc/BRIEF.md
# Slave Port Bus Arbiter

This block decides which of up to eleven bus masters may drive one slave port. Each slave in a crossbar gets its own copy, so every slave can run its own policy. A master raises its request line and keeps it high for as long as its transfer or burst lasts. The arbiter answers with a one-hot grant and an owner index, both registered. The winner holds the port until it drops its request.

Two policies are available: fixed priority and round-robin. In fixed-priority mode each master carries a two-bit level. In round-robin mode the search starts at the master after the last one granted. A programmable slot limit caps how many consecutive cycles one owner can keep the port while others wait, so bursts of unknown length cannot starve the rest.

When nobody requests, the port can be parked on a default master: none, the last real owner, or a fixed index. A parked master that then makes a request needs no arbitration cycle. In "none" mode the first access after idle pays one cycle.

Top module: `slave_arbiter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, gnt_o is all zero and owner_vld_o is low.
- R2: gnt_o is one-hot or zero. When owner_vld_o is high, owner_o is the index of the single set bit of gnt_o. A decision is taken from the inputs present before a rising clock edge and is visible right after that edge.
- R3: With policy_i = 0 (fixed priority), the requester with the highest two-bit level wins. The level of master i is prio_i[2*i+1:2*i]. Among equal levels, the lower index wins.
- R4: With policy_i = 1 (round-robin), the search for a winner starts at the index after the last master granted on request and wraps from the top index to 0.
- R5: A real owner keeps the grant for as long as its request stays high and its slot has not expired. With slot_limit_i = 0, no burst is ever broken.
- R6: With slot_limit_i = L > 0, once an owner has held the grant for L consecutive cycles, its slot expires. If any other master is requesting at that point, the owner is excluded from that arbitration and loses the grant. If no other master is requesting, the owner is granted again with a fresh slot.
- R7: With dflt_mode_i = 0 (none) or 3 (treated as none), an idle cycle with no request leaves no grant.
- R8: With dflt_mode_i = 1 (last), an idle cycle parks the grant on the last master granted on request. If no master has been granted yet, there is no grant.
- R9: With dflt_mode_i = 2 (fixed), an idle cycle parks the grant on dflt_idx_i.
- R10: A parked master has no advantage over other requesters. When requests arrive while the port is parked, the selected policy alone chooses the winner, and the parked master is simply one of the candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Per-master request, held high through a burst |
| policy_i | input | 1 | 0 selects fixed priority, 1 selects round-robin |
| dflt_mode_i | input | 2 | Default master: 0 none, 1 last, 2 fixed, 3 none |
| dflt_idx_i | input | IDX_W | Master index used in fixed default mode |
| prio_i | input | N_MST*PRIO_W | Packed per-master priority levels |
| slot_limit_i | input | SLOT_W | Maximum cycles per grant; 0 disables breaking |
| gnt_o | output | N_MST | One-hot grant |
| owner_o | output | IDX_W | Index of the granted master |
| owner_vld_o | output | 1 | A master currently holds the port |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. This covers a new winner, a kept burst, a broken slot and a parked default. The driver applies each request pattern just after a falling edge and queues the outcome expected from the requirements for that input. The monitor removes and compares one item at every falling edge, which falls half a period after the single register stage that produces the result. Configuration changes are made only after the edge that uses the previous setting, so each queued item depends on one known set of inputs.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_RR    = 1'b1
  } arb_policy_e;

  typedef enum logic [1:0] {
    DFLT_NONE  = 2'd0,
    DFLT_LAST  = 2'd1,
    DFLT_FIXED = 2'd2,
    DFLT_RSVD  = 2'd3
  } dflt_mode_e;
endpackage

// File: rtl/arb_fixed_prio.sv
module arb_fixed_prio #(
  parameter int N_MST  = 11,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic [N_MST-1:0]        cand_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]        win_o
);
  logic              found;
  logic [PRIO_W-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '0;
    win_o = '0;
    for (int i = 0; i < N_MST; i++) begin
      // strict compare keeps the lower index on ties
      if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        found = 1'b1;
        best  = prio_i[i*PRIO_W +: PRIO_W];
        win_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (|cand_i) begin
      p_win_is_req_r3: assert (cand_i[win_o]);
    end
  end
endmodule

// File: rtl/arb_round_robin.sv
module arb_round_robin #(
  parameter int N_MST = 11,
  parameter int IDX_W = 4
) (
  input  logic [N_MST-1:0] cand_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] win_o
);
  logic found;
  int   idx;

  always_comb begin
    found = 1'b0;
    win_o = '0;
    idx   = 0;
    for (int k = 1; k <= N_MST; k++) begin
      idx = (int'(ptr_i) + k) % N_MST;
      if (!found && cand_i[idx]) begin
        found = 1'b1;
        win_o = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    if (|cand_i) begin
      p_win_is_req_r4: assert (cand_i[win_o]);
    end
  end
endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [SLOT_W-1:0] limit_i,
  output logic [SLOT_W-1:0] cnt_o,
  output logic              expire_o
);
  logic [SLOT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start_i)                     cnt_d = SLOT_W'(1);
    else if (run_i && cnt_q != '1)   cnt_d = cnt_q + SLOT_W'(1);
    else if (run_i)                  cnt_d = cnt_q;
    else                             cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign expire_o = (limit_i != '0) && (cnt_q >= limit_i);

  p_cnt_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !run_i) |=> (cnt_q == '0));
endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST  = 11,
  parameter int PRIO_W = 2,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST-1:0]        req_i,
  input  logic                    policy_i,
  input  logic [1:0]              dflt_mode_i,
  input  logic [IDX_W-1:0]        dflt_idx_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  input  logic [SLOT_W-1:0]       slot_limit_i,
  output logic [N_MST-1:0]        gnt_o,
  output logic [IDX_W-1:0]        owner_o,
  output logic                    owner_vld_o
);
  logic [IDX_W-1:0] owner_q, owner_d, last_q, last_d;
  logic             vld_q, vld_d, parked_q, parked_d, last_vld_q, last_vld_d;
  logic [N_MST-1:0] owner_oh, cand, others;
  logic [IDX_W-1:0] win_fp, win_rr, win;
  logic             real_own, expire, hold, excl, start, run;
  logic [SLOT_W-1:0] slot_cnt;
  arb_policy_e      policy;
  dflt_mode_e       dmode;

  assign policy   = arb_policy_e'(policy_i);
  assign dmode    = dflt_mode_e'(dflt_mode_i);
  assign owner_oh = vld_q ? (N_MST'(1) << owner_q) : '0;
  assign real_own = vld_q && !parked_q;
  assign others   = req_i & ~owner_oh;
  assign hold     = real_own && |(req_i & owner_oh) && !expire;
  assign excl     = real_own && expire && |others;
  assign cand     = excl ? others : req_i;

  arb_fixed_prio #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_fp (
    .cand_i (cand),
    .prio_i (prio_i),
    .win_o  (win_fp)
  );

  arb_round_robin #(.N_MST(N_MST), .IDX_W(IDX_W)) u_rr (
    .cand_i (cand),
    .ptr_i  (last_q),
    .win_o  (win_rr)
  );

  assign win = (policy == ARB_RR) ? win_rr : win_fp;

  always_comb begin
    owner_d    = owner_q;
    vld_d      = vld_q;
    parked_d   = parked_q;
    last_d     = last_q;
    last_vld_d = last_vld_q;
    start      = 1'b0;
    run        = 1'b0;
    if (hold) begin
      run = 1'b1;
    end else if (|cand) begin
      owner_d    = win;
      vld_d      = 1'b1;
      parked_d   = 1'b0;
      last_d     = win;
      last_vld_d = 1'b1;
      start      = 1'b1;
    end else begin
      unique case (dmode)
        DFLT_LAST: begin
          owner_d  = last_q;
          vld_d    = last_vld_q;
          parked_d = last_vld_q;
        end
        DFLT_FIXED: begin
          owner_d  = dflt_idx_i;
          vld_d    = 1'b1;
          parked_d = 1'b1;
        end
        default: begin
          vld_d    = 1'b0;
          parked_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q    <= '0;
      vld_q      <= 1'b0;
      parked_q   <= 1'b0;
      last_q     <= IDX_W'(N_MST - 1);
      last_vld_q <= 1'b0;
    end else begin
      owner_q    <= owner_d;
      vld_q      <= vld_d;
      parked_q   <= parked_d;
      last_q     <= last_d;
      last_vld_q <= last_vld_d;
    end
  end

  arb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (run),
    .limit_i  (slot_limit_i),
    .cnt_o    (slot_cnt),
    .expire_o (expire)
  );

  assign gnt_o       = owner_oh;
  assign owner_o     = owner_q;
  assign owner_vld_o = vld_q;

  p_onehot_gnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_burst_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (real_own && |(req_i & gnt_o) && slot_limit_i == '0)
      |=> (owner_vld_o && owner_o == $past(owner_o)));

  p_slot_break_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (real_own && slot_limit_i != '0 && slot_cnt >= slot_limit_i && |others)
      |=> (owner_o != $past(owner_o)));

  p_idle_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && (dmode == DFLT_NONE || dmode == DFLT_RSVD)) |=> !owner_vld_o);

  p_idle_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && dmode == DFLT_FIXED)
      |=> (owner_vld_o && owner_o == $past(dflt_idx_i)));
endmodule

// File: tb/slave_arbiter_test.sv
module slave_arbiter_test;
  localparam int N  = 11;
  localparam int PW = 2;
  localparam int SW = 8;
  localparam int IW = 4;

  typedef struct {
    bit    vld;
    int    idx;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          policy = 1'b0;
  logic [1:0]    dmode = 2'd0;
  logic [IW-1:0] didx = '0;
  logic [N*PW-1:0] prio = '0;
  logic [SW-1:0] slim = '0;
  logic [N-1:0]  gnt;
  logic [IW-1:0] owner;
  logic          owner_vld;

  int   n_chk = 0, n_fail = 0;
  exp_t sb[$];
  bit   done = 1'b0;

  always #5 clk = ~clk;

  slave_arbiter #(.N_MST(N), .PRIO_W(PW), .SLOT_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .policy_i(policy),
    .dflt_mode_i(dmode), .dflt_idx_i(didx), .prio_i(prio),
    .slot_limit_i(slim), .gnt_o(gnt), .owner_o(owner), .owner_vld_o(owner_vld)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // monitor: one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        logic [N-1:0] eg;
        e  = sb.pop_front();
        eg = e.vld ? (N'(1) << e.idx) : '0;
        check(gnt === eg && owner_vld === e.vld && (!e.vld || owner === IW'(e.idx)),
              e.tag, $sformatf("gnt=%h vld=%0b own=%0d", gnt, owner_vld, owner),
              $sformatf("gnt=%h vld=%0b own=%0d", eg, e.vld, e.idx));
      end
    end
  end

  task automatic step(input logic [N-1:0] r, input bit v, input int idx, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    req = r;
    e.vld = v; e.idx = idx; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cfg(input bit pol, input logic [1:0] dm, input int di, input int lim);
    @(posedge clk);
    #1;
    policy = pol; dmode = dm; didx = IW'(di); slim = SW'(lim);
  endtask

  task automatic set_prio(input int i, input int v);
    prio[i*PW +: PW] = PW'(v);
  endtask

  function automatic logic [N-1:0] m(input int a, input int b = -1, input int c = -1);
    logic [N-1:0] r = '0;
    if (a >= 0) r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gnt === '0 && owner_vld === 1'b0, "R1 in reset",
          $sformatf("%h/%0b", gnt, owner_vld), "0/0");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(gnt === '0 && owner_vld === 1'b0, "R1 after release",
          $sformatf("%h/%0b", gnt, owner_vld), "0/0");

    // R8: last mode with no history parks nothing
    cfg(1'b0, 2'd1, 0, 0);
    step('0, 0, 0, "R8 no history");

    // R3 R5: fixed priority, equal levels, no breaking
    cfg(1'b0, 2'd0, 0, 0);
    step(m(2, 5), 1, 2, "R3 tie lower index");
    step(m(2, 5), 1, 2, "R5 burst kept");
    step(m(2, 5), 1, 2, "R5 burst kept limit0");
    step(m(5),    1, 5, "R2 handover");
    step('0,      0, 0, "R7 idle none");

    // R3: levels
    cfg(1'b0, 2'd0, 0, 0);
    set_prio(7, 3); set_prio(1, 1);
    step(m(1, 7), 1, 7, "R3 higher level wins");
    step(m(1),    1, 1, "R3 remaining");
    step('0,      0, 0, "R7 idle");

    // R4: round robin from last granted (1)
    cfg(1'b1, 2'd0, 0, 0);
    prio = '0;
    step(m(0, 3, 9), 1, 3, "R4 after last");
    step(m(0, 9),    1, 9, "R4 next");
    step(m(0, 3),    1, 0, "R4 wrap");
    step('0,         0, 0, "R7 idle rr");

    // R6: slot limit 3 in round robin
    cfg(1'b1, 2'd0, 0, 3);
    step(m(4, 6), 1, 4, "R6 slot c1");
    step(m(4, 6), 1, 4, "R6 slot c2");
    step(m(4, 6), 1, 4, "R6 slot c3");
    step(m(4, 6), 1, 6, "R6 broken");
    step(m(4, 6), 1, 6, "R6 slot c2b");
    step(m(4, 6), 1, 6, "R6 slot c3b");
    step(m(4, 6), 1, 4, "R6 broken back");
    step('0,      0, 0, "R7 idle");

    // R6: fixed priority, owner excluded on break
    cfg(1'b0, 2'd0, 0, 2);
    set_prio(7, 3);
    step(m(1, 7), 1, 7, "R6 fp c1");
    step(m(1, 7), 1, 7, "R6 fp c2");
    step(m(1, 7), 1, 1, "R6 top excluded");
    step(m(1, 7), 1, 1, "R6 low c2");
    step(m(1, 7), 1, 7, "R6 top back");
    step(m(7),    1, 7, "R6 alone c2");
    step(m(7),    1, 7, "R6 alone regrant");
    step(m(7),    1, 7, "R6 alone kept");
    step('0,      0, 0, "R7 idle");

    // R8: park on last
    cfg(1'b0, 2'd1, 0, 0);
    prio = '0;
    step(m(8), 1, 8, "R8 grant");
    step('0,   1, 8, "R8 parked");
    step('0,   1, 8, "R8 parked still");
    step(m(3), 1, 3, "R10 other wins from park");
    step('0,   1, 3, "R8 parked new");

    // R9 R10: park on fixed index
    cfg(1'b0, 2'd2, 10, 0);
    step('0,       1, 10, "R9 parked");
    step(m(2),     1, 2,  "R9 requester");
    step('0,       1, 10, "R9 parked again");
    step(m(2, 10), 1, 2,  "R10 no park advantage");
    step('0,       1, 10, "R9 parked 3");
    step(m(10),    1, 10, "R10 parked requests");
    step('0,       1, 10, "R9 idle");

    // R7: reserved code acts as none
    cfg(1'b0, 2'd3, 10, 0);
    step('0, 0, 0, "R7 reserved mode");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule